// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual page number into its final page table entry by walking a radix page table that lives in memory. It is the refill engine behind a translation cache. When that cache misses, it hands the walker a virtual page number together with the table root of the running process. The walker then reads one table entry per level and reports either the leaf entry or a fault.

The virtual page number is cut into equal slices, one per table level. The top slice indexes the root table. Each valid entry that is not a leaf gives the physical page that holds the next table down. An entry whose valid bit is clear ends the walk at once with a fault and the level where it stopped. Because the walk stops there, tables below unallocated entries never have to exist. The walker handles one walk at a time and keeps at most one memory read in flight.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `walk_busy_o`, `walk_done_o`, `walk_fault_o` and `mem_rd_valid_o` are all low.
- R2: A `walk_req_i` accepted while idle makes the first memory read in the next cycle. Its address is `ptbr_i` plus 4 times the most significant VPN slice (bits [50:34] by default).
- R3: Each later read uses the next lower VPN slice (bits [33:17], then [16:0]). Its address is {previous entry bits [24:5], 13 zero bits} plus 4 times that slice.
- R4: Entry layout: bit 0 valid, bit 1 dirty, bit 2 read, bit 3 write, bit 4 execute, bits [24:5] physical page number. A valid entry returned at the last level raises `walk_done_o` for exactly one cycle, in the cycle after the response. In that cycle `walk_leaf_o` equals the returned word.
- R5: An entry with bit 0 clear at any level raises `walk_fault_o` for exactly one cycle, in the cycle after the response. `walk_fault_lvl_o` gives that level (0 = root). No further read is made, and done and fault never rise together.
- R6: `walk_busy_o` is high from the cycle after the request is accepted until the cycle in which done or fault rises, where it falls. A `walk_req_i` seen while busy is ignored and does not change the addresses read.
- R7: At most one read is outstanding. The next read is not issued before the response to the previous one.
- R8: A `mem_rsp_valid_i` arriving while no read is outstanding has no effect: no done, no fault, no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_req_i | input | 1 | Start a walk (taken only while idle) |
| walk_vpn_i | input | 51 | Virtual page number to resolve |
| ptbr_i | input | 33 | Physical address of the root table |
| walk_busy_o | output | 1 | Walk in progress |
| walk_done_o | output | 1 | One-cycle pulse: leaf entry ready |
| walk_fault_o | output | 1 | One-cycle pulse: invalid entry met |
| walk_fault_lvl_o | output | 2 | Level of the invalid entry |
| walk_leaf_o | output | 25 | Leaf entry of the last completed walk |
| mem_rd_valid_o | output | 1 | One-cycle read request |
| mem_rd_addr_o | output | 33 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 25 | Entry word returned by memory |

## Verification
The first read comes one cycle after the request edge. Each further read comes one cycle after the response edge for the previous level. Done or fault comes one cycle after the final response edge, and busy falls in that same cycle. The bench drives and samples only on falling edges, so every check reads a value that settled after the edge that produced it. A memory responder with adjustable latency logs every read address and flags any read made while a response is still owed. A separate walk of the same sparse table model gives the expected address list and outcome for each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        PTW_IDLE  = 2'd0,
        PTW_ISSUE = 2'd1,
        PTW_WAIT  = 2'd2
    } ptw_state_e;

    localparam int PTE_FLAG_W = 5;
    localparam int PTE_VALID  = 0;
    localparam int PTE_DIRTY  = 1;
    localparam int PTE_READ   = 2;
    localparam int PTE_WRITE  = 3;
    localparam int PTE_EXEC   = 4;

endpackage

// File: rtl/ptw_seg_pick.sv
module ptw_seg_pick #(
    parameter int LEVELS = 3,
    parameter int SEG_W  = 17,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS*SEG_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic [SEG_W-1:0]        seg
);
    logic [SEG_W-1:0] slices [LEVELS];

    // level 0 takes the most significant slice
    for (genvar l = 0; l < LEVELS; l++) begin : g_slice
        assign slices[l] = vpn[(LEVELS-1-l)*SEG_W +: SEG_W];
    end

    always_comb begin
        seg = slices[0];
        for (int l = 1; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) seg = slices[l];
        end
    end
endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
    parameter int PA_W      = 33,
    parameter int SEG_W     = 17,
    parameter int PTE_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [SEG_W-1:0] seg,
    output logic [PA_W-1:0]  addr
);
    localparam int OFF_SH = $clog2(PTE_BYTES);

    logic [PA_W-1:0] offset;

    always_comb begin
        offset = PA_W'(seg) << OFF_SH;
        addr   = base + offset;
    end
endmodule

// File: rtl/ptw_pte_unpack.sv
module ptw_pte_unpack
    import ptw_pkg::*;
#(
    parameter int PA_W   = 33,
    parameter int PAGE_W = 13
) (
    input  logic [PA_W-PAGE_W+PTE_FLAG_W-1:0] pte,
    output logic                              valid,
    output logic [PA_W-1:0]                   next_base
);
    localparam int PPN_W = PA_W - PAGE_W;

    logic [PPN_W-1:0] ppn;

    always_comb begin
        valid     = pte[PTE_VALID];
        ppn       = pte[PTE_FLAG_W +: PPN_W];
        next_base = {ppn, {PAGE_W{1'b0}}};
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS    = 3,
    parameter int SEG_W     = 17,
    parameter int PA_W      = 33,
    parameter int PAGE_W    = 13,
    parameter int PTE_BYTES = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         walk_req_i,
    input  logic [LEVELS*SEG_W-1:0]                      walk_vpn_i,
    input  logic [PA_W-1:0]                              ptbr_i,
    output logic                                         walk_busy_o,
    output logic                                         walk_done_o,
    output logic                                         walk_fault_o,
    output logic [((LEVELS > 1) ? $clog2(LEVELS) : 1)-1:0] walk_fault_lvl_o,
    output logic [PA_W-PAGE_W+5-1:0]                     walk_leaf_o,
    output logic                                         mem_rd_valid_o,
    output logic [PA_W-1:0]                              mem_rd_addr_o,
    input  logic                                         mem_rsp_valid_i,
    input  logic [PA_W-PAGE_W+5-1:0]                     mem_rsp_data_i
);
    localparam int VPN_W = LEVELS * SEG_W;
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int PTE_W = PA_W - PAGE_W + PTE_FLAG_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        ptw_state_e       st;
        logic [VPN_W-1:0] vpn;
        logic [PA_W-1:0]  base;
        logic [LVL_W-1:0] lvl;
        logic             done;
        logic             fault;
        logic [PTE_W-1:0] leaf;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [SEG_W-1:0] cur_seg;
    logic [PA_W-1:0]  entry_addr;
    logic             rsp_valid_bit;
    logic [PA_W-1:0]  rsp_next_base;

    ptw_seg_pick #(
        .LEVELS (LEVELS),
        .SEG_W  (SEG_W),
        .LVL_W  (LVL_W)
    ) u_seg (
        .vpn   (r_q.vpn),
        .level (r_q.lvl),
        .seg   (cur_seg)
    );

    ptw_addr_calc #(
        .PA_W      (PA_W),
        .SEG_W     (SEG_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_addr (
        .base (r_q.base),
        .seg  (cur_seg),
        .addr (entry_addr)
    );

    ptw_pte_unpack #(
        .PA_W   (PA_W),
        .PAGE_W (PAGE_W)
    ) u_pte (
        .pte       (mem_rsp_data_i),
        .valid     (rsp_valid_bit),
        .next_base (rsp_next_base)
    );

    // next-state computation
    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            PTW_IDLE: begin
                if (walk_req_i) begin
                    r_d.st   = PTW_ISSUE;
                    r_d.vpn  = walk_vpn_i;
                    r_d.base = ptbr_i;
                    r_d.lvl  = '0;
                end
            end
            PTW_ISSUE: begin
                r_d.st = PTW_WAIT;
            end
            PTW_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!rsp_valid_bit) begin
                        r_d.fault = 1'b1;
                        r_d.st    = PTW_IDLE;
                    end else if (r_q.lvl == LAST_LVL) begin
                        r_d.done = 1'b1;
                        r_d.leaf = mem_rsp_data_i;
                        r_d.st   = PTW_IDLE;
                    end else begin
                        r_d.base = rsp_next_base;
                        r_d.lvl  = r_q.lvl + 1'b1;
                        r_d.st   = PTW_ISSUE;
                    end
                end
            end
            default: r_d.st = PTW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign walk_busy_o      = (r_q.st != PTW_IDLE);
    assign walk_done_o      = r_q.done;
    assign walk_fault_o     = r_q.fault;
    assign walk_fault_lvl_o = r_q.lvl;
    assign walk_leaf_o      = r_q.leaf;
    assign mem_rd_valid_o   = (r_q.st == PTW_ISSUE);
    assign mem_rd_addr_o    = entry_addr;

    AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_busy_o) |-> mem_rd_valid_o);                    // R2
    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy_o |-> (r_q.lvl <= LAST_LVL));                    // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done_o |=> !walk_done_o);                             // R4
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fault_o |=> !walk_fault_o);                           // R5
    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done_o && walk_fault_o));                           // R5
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(walk_busy_o) |-> (walk_done_o || walk_fault_o));     // R6
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o |=> !mem_rd_valid_o);                       // R7
    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!walk_busy_o && mem_rsp_valid_i) |=> !(walk_done_o || walk_fault_o)); // R8
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    localparam int LV  = 3;
    localparam int SW  = 17;
    localparam int PA  = 33;
    localparam int PG  = 13;
    localparam int PB  = 4;
    localparam int VW  = LV * SW;
    localparam int PTW = PA - PG + 5;
    localparam int PPW = PA - PG;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           walk_req = 1'b0;
    logic [VW-1:0]  walk_vpn = '0;
    logic [PA-1:0]  ptbr = '0;
    logic           busy, done, fault;
    logic [1:0]     flvl;
    logic [PTW-1:0] leaf;
    logic           rd_valid;
    logic [PA-1:0]  rd_addr;
    logic           rsp_valid = 1'b0;
    logic [PTW-1:0] rsp_data = '0;

    always #2 clk = ~clk;

    ptw_walker uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .walk_req_i       (walk_req),
        .walk_vpn_i       (walk_vpn),
        .ptbr_i           (ptbr),
        .walk_busy_o      (busy),
        .walk_done_o      (done),
        .walk_fault_o     (fault),
        .walk_fault_lvl_o (flvl),
        .walk_leaf_o      (leaf),
        .mem_rd_valid_o   (rd_valid),
        .mem_rd_addr_o    (rd_addr),
        .mem_rsp_valid_i  (rsp_valid),
        .mem_rsp_data_i   (rsp_data)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // sparse memory model and responder
    logic [PTW-1:0] pmem [logic [PA-1:0]];
    logic [PA-1:0]  alog [16];
    int             alog_n = 0;
    int             lat = 1;
    int             stray_req = 0;
    int             stray_done = 0;

    function automatic logic [PTW-1:0] mem_rd(input logic [PA-1:0] a);
        return pmem.exists(a) ? pmem[a] : '0;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (stray_req != stray_done) begin
                rsp_valid  = 1'b1;
                rsp_data   = {20'hABCDE, 5'b11111};
                stray_done = stray_req;
            end else if (rd_valid) begin
                alog[alog_n % 16] = rd_addr;
                alog_n++;
                rsp_data = mem_rd(rd_addr);
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    if (rd_valid) chk(1'b0, "R7 read while response owed", 1, 0);
                end
                rsp_valid = 1'b1;
            end
        end
    end

    function automatic logic [SW-1:0] seg_of(input logic [VW-1:0] v, input int l);
        return v[(LV-1-l)*SW +: SW];
    endfunction

    // independent expected walk
    logic [PA-1:0]  exp_a [4];
    int             exp_n;
    bit             exp_done;
    int             exp_fl;
    logic [PTW-1:0] exp_leaf;

    task automatic model_walk(input logic [VW-1:0] v, input logic [PA-1:0] p);
        logic [PA-1:0]  base;
        logic [PA-1:0]  a;
        logic [PTW-1:0] e;
        base = p; exp_n = 0; exp_done = 0; exp_fl = -1; exp_leaf = '0;
        for (int l = 0; l < LV; l++) begin
            a = base + PA'(seg_of(v, l)) * PB;
            exp_a[exp_n] = a;
            exp_n++;
            e = mem_rd(a);
            if (!e[0]) begin exp_fl = l; return; end
            if (l == LV-1) begin exp_done = 1; exp_leaf = e; return; end
            base = {e[PTW-1:5], {PG{1'b0}}};
        end
    endtask

    task automatic build_chain(input logic [VW-1:0] v, input logic [PA-1:0] p,
                               input int fault_at, input logic [4:0] flags);
        logic [PA-1:0]  base;
        logic [PA-1:0]  a;
        logic [PPW-1:0] ppn;
        pmem.delete();
        base = p;
        for (int l = 0; l < LV; l++) begin
            a   = base + PA'(seg_of(v, l)) * PB;
            ppn = PPW'(20'h00040 + 20'h0011F * (l + 1) + v[l*4 +: 4]);
            if (l == fault_at) begin
                pmem[a] = {ppn, 5'b11110};
                break;
            end
            pmem[a] = {ppn, (l == LV-1) ? flags : 5'b00001};
            base = {ppn, {PG{1'b0}}};
        end
    endtask

    bit             got_done, got_fault;
    logic [1:0]     got_lvl;
    logic [PTW-1:0] got_leaf;
    int             got_n;

    task automatic do_walk(input logic [VW-1:0] v, input logic [PA-1:0] p,
                           input int latency, input bit junk, input string tag);
        int start;
        bit hit;
        lat = latency;
        start = alog_n;
        hit = 0;
        @(negedge clk);
        walk_req = 1'b1; walk_vpn = v; ptbr = p;
        @(negedge clk);
        walk_req = 1'b0;
        chk(busy === 1'b1, {"R6 busy after accept ", tag}, busy, 1);
        for (int k = 0; k < 200; k++) begin
            if (done || fault) begin hit = 1; break; end
            if (!busy) chk(1'b0, {"R6 busy dropped early ", tag}, 0, 1);
            if (junk && k == 1) begin
                walk_req = 1'b1; walk_vpn = ~v; ptbr = p ^ 33'h1_0000_0000;
            end else begin
                walk_req = 1'b0;
            end
            @(negedge clk);
        end
        walk_req = 1'b0;
        chk(hit, {"R4 walk finished ", tag}, hit, 1);
        got_done = done; got_fault = fault; got_lvl = flvl; got_leaf = leaf;
        got_n = alog_n - start;
        chk(busy === 1'b0, {"R6 busy falls with result ", tag}, busy, 0);
        @(negedge clk);
        chk(!done && !fault, {"R4 R5 result is one-cycle pulse ", tag}, {done, fault}, 0);
        model_walk(v, p);
        chk(got_n == exp_n, {"R5 R7 read count ", tag}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(alog[(start + i) % 16] === exp_a[i],
                (i == 0) ? {"R2 root address ", tag} : {"R3 level address ", tag},
                alog[(start + i) % 16], exp_a[i]);
        chk(got_done == exp_done, {"R4 done ", tag}, got_done, exp_done);
        chk(got_fault == (exp_fl >= 0), {"R5 fault ", tag}, got_fault, exp_fl >= 0);
        if (exp_done) chk(got_leaf === exp_leaf, {"R4 leaf word ", tag}, got_leaf, exp_leaf);
        if (exp_fl >= 0) chk(int'(got_lvl) == exp_fl, {"R5 fault level ", tag}, got_lvl, exp_fl);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0,     "R1 busy", busy, 0);
        chk(done === 1'b0,     "R1 done", done, 0);
        chk(fault === 1'b0,    "R1 fault", fault, 0);
        chk(rd_valid === 1'b0, "R1 read valid", rd_valid, 0);
    endtask

    task automatic t_full_walk;
        logic [VW-1:0] v;
        v = 51'h1_2345_6789_ABCD;
        build_chain(v, 33'h0_0010_0000, 99, 5'b11101);
        do_walk(v, 33'h0_0010_0000, 1, 0, "full fast");
        v = 51'h6_0F0F_1234_5555;
        build_chain(v, 33'h1_0000_2000, 99, 5'b00111);
        do_walk(v, 33'h1_0000_2000, 4, 0, "full slow");
    endtask

    task automatic t_faults;
        logic [VW-1:0] v;
        v = 51'h3_3333_2222_1111;
        for (int f = 0; f < LV; f++) begin
            build_chain(v, 33'h0_0040_0000, f, 5'b00001);
            do_walk(v, 33'h0_0040_0000, 2, 0, $sformatf("fault lvl %0d", f));
        end
    endtask

    task automatic t_boundary;
        build_chain({VW{1'b1}}, 33'h0_0008_0000, 99, 5'b01011);
        do_walk({VW{1'b1}}, 33'h0_0008_0000, 1, 0, "vpn all ones");
        build_chain('0, 33'h0, 99, 5'b10101);
        do_walk('0, 33'h0, 1, 0, "vpn zero");
    endtask

    task automatic t_busy_ignore;
        logic [VW-1:0] v;
        v = 51'h2_AAAA_5555_0F0F;
        build_chain(v, 33'h0_0020_0000, 99, 5'b11111);
        do_walk(v, 33'h0_0020_0000, 3, 1, "R6 request while busy");
    endtask

    task automatic t_stray;
        int start;
        start = alog_n;
        stray_req++;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!done && !fault && !busy, "R8 stray response ignored", {busy, done, fault}, 0);
        end
        chk(alog_n == start, "R8 no read after stray response", alog_n - start, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_walk();
        t_faults();
        t_boundary();
        t_busy_ignore();
        t_stray();
        t_full_walk();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule